// File: doc/BRIEF.md
# Windowed Pre/Post Sum Accumulators

This block produces the raw energy information for one digitizer channel. The sample stream passes through two windows. The post window holds the most recent samples, which is the flat top after the rise. A gap of programmable length follows it. The pre window lies behind the gap and holds the baseline. Each window keeps a boxcar sum of every sample inside it. The sum changes every clock by the sample that enters the window minus the sample that leaves it. Downstream logic turns the two sums into an amplitude and applies baseline and pole-zero correction.

When the discriminator fires, the block captures both sums and the timestamp as one event record. The record is ready one cycle later, so fires on consecutive cycles are all accepted. The record captured before it is kept and shown next to the newest one, which gives carry-over reporting of the previous event. Any change to a length setting restarts filling. The sums-valid flag then stays low until the whole span has been refilled with fresh samples.

Top module: `prepost_sum_unit`

## Requirements
- R1: When a fire is sampled in cycle c, the captured post sum equals the sum of the `post_len_i` samples presented in cycles c-post_len_i to c-1.
- R2: When a fire is sampled in cycle c, the captured pre sum equals the sum of the `pre_len_i` samples presented in cycles c-P-G-pre_len_i to c-P-G-1, where P is `post_len_i` and G is `gap_len_i`.
- R3: Window lengths may be any value from 1 to 512. With 512-sample windows and every sample at 16383, each sum reads 8388096 exactly, with no wrap in the 24-bit result.
- R4: The gap may be any value from 0 to 255. A gap of 0 places the pre window directly behind the post window.
- R5: A fire sampled in cycle c captures `ts_i` of cycle c together with the two sums of that cycle. `evt_valid_o` is high for exactly cycle c+1.
- R6: Fires on consecutive cycles each produce their own event record, and none is lost.
- R7: Each fire moves the record that was current before it (timestamp, sums, ok flag) onto the `prev_*` outputs. `prev_valid_o` rises with the second fire after reset and then stays high.
- R8: A change of any of the three length inputs restarts filling. `sums_valid_o` is low from then until pre_len_i+post_len_i+gap_len_i samples have been taken after the restart. `evt_ok_o` records the value of `sums_valid_o` in the fire cycle.
- R9: While reset is held, `sums_valid_o`, `evt_valid_o`, `prev_valid_o` and all event sums and timestamps are zero.
- R10: While no fire is sampled, the `evt_*` record holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | ADC sample, unsigned, one per clock |
| pre_len_i | input | 10 | Pre window length, 1..512 |
| post_len_i | input | 10 | Post window length, 1..512 |
| gap_len_i | input | 8 | Gap between the two windows, 0..255 |
| fire_i | input | 1 | Discriminator fire |
| ts_i | input | 48 | Current timestamp |
| sums_valid_o | output | 1 | Both windows hold fresh samples only |
| evt_valid_o | output | 1 | One-cycle pulse when a new record is ready |
| evt_ok_o | output | 1 | Sums were valid when the record was captured |
| evt_pre_o | output | 24 | Captured pre sum |
| evt_post_o | output | 24 | Captured post sum |
| evt_ts_o | output | 48 | Captured timestamp |
| prev_valid_o | output | 1 | A previous record exists |
| prev_ok_o | output | 1 | Ok flag of the previous record |
| prev_pre_o | output | 24 | Pre sum of the previous record |
| prev_post_o | output | 24 | Post sum of the previous record |
| prev_ts_o | output | 48 | Timestamp of the previous record |

## Verification
A running sum never corrects itself. If an addend or a subtrahend is wrong even once, the offset stays in every later captured sum, and the next fire with valid sums shows it. A read pointer off by one, or a leaving sample that is not gated, moves the window edge. The error then shows within one window length, because the sum tracks the wrong slice of a varying input. Faults in fill tracking or restart show cycle by cycle as a `sums_valid_o` edge at the wrong place. They also show as a wrong `evt_ok_o` on a fire placed right at the refill boundary.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int unsigned SAMPLE_W = 14;
  localparam int unsigned SUM_W    = 24;
  localparam int unsigned TS_W     = 48;
  localparam int unsigned MAX_SAMPLE = (1 << SAMPLE_W) - 1;

  typedef struct packed {
    logic             ok;
    logic [SUM_W-1:0] pre;
    logic [SUM_W-1:0] post;
    logic [TS_W-1:0]  ts;
  } psa_evt_t;
endpackage

// File: rtl/psa_delay.sv
module psa_delay import psa_pkg::*; #(
  parameter int unsigned AW    = 9,
  parameter int unsigned LEN_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [SAMPLE_W-1:0] din_i,
  output logic [SAMPLE_W-1:0] dout_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [SAMPLE_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]       wp_q;
  logic [AW-1:0]       rd_addr;
  logic [LEN_W-1:0]    fill_q;
  logic                filled;
  logic [SAMPLE_W-1:0] tap;

  assign filled  = fill_q >= len_i;
  assign rd_addr = wp_q - AW'(len_i);
  // slots not yet rewritten since restart read as zero
  assign tap     = filled ? mem_q[rd_addr] : '0;
  assign dout_o  = (len_i == '0) ? din_i : tap;

  always_ff @(posedge clk_i) begin
    mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q <= wp_q + 1'b1;
      if (restart_i)   fill_q <= '0;
      else if (!filled) fill_q <= fill_q + 1'b1;
    end
  end

  p_fill_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || restart_i)
    fill_q <= len_i);
endmodule

// File: rtl/psa_accum.sv
module psa_accum import psa_pkg::*; #(
  parameter int unsigned LEN_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [SAMPLE_W-1:0] add_i,
  input  logic [SAMPLE_W-1:0] sub_i,
  output logic [SUM_W-1:0]    sum_o
);
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sum_q <= '0;
    else if (restart_i) sum_q <= '0;
    else                sum_q <= sum_q + SUM_W'(add_i) - SUM_W'(sub_i);
  end

  assign sum_o = sum_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || restart_i)
    sum_q <= SUM_W'(len_i) * SUM_W'(MAX_SAMPLE));
endmodule

// File: rtl/psa_event_latch.sv
module psa_event_latch import psa_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             ok_i,
  input  logic [SUM_W-1:0] pre_i,
  input  logic [SUM_W-1:0] post_i,
  input  logic [TS_W-1:0]  ts_i,
  output psa_evt_t         cur_o,
  output logic             cur_valid_o,
  output psa_evt_t         prev_o,
  output logic             prev_valid_o
);
  psa_evt_t cur_q, prev_q;
  logic     cur_valid_q, has_cur_q, prev_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q        <= '0;
      prev_q       <= '0;
      cur_valid_q  <= 1'b0;
      has_cur_q    <= 1'b0;
      prev_valid_q <= 1'b0;
    end else begin
      cur_valid_q <= fire_i;
      if (fire_i) begin
        cur_q        <= '{ok: ok_i, pre: pre_i, post: post_i, ts: ts_i};
        prev_q       <= cur_q;
        has_cur_q    <= 1'b1;
        prev_valid_q <= prev_valid_q | has_cur_q;
      end
    end
  end

  assign cur_o        = cur_q;
  assign cur_valid_o  = cur_valid_q;
  assign prev_o       = prev_q;
  assign prev_valid_o = prev_valid_q;

  p_ts_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (cur_o.ts == $past(ts_i)) && cur_valid_o);
  p_prev_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> prev_o == $past(cur_o));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(cur_o) && !cur_valid_o);
endmodule

// File: rtl/prepost_sum_unit.sv
module prepost_sum_unit import psa_pkg::*; #(
  parameter int unsigned MAX_LEN = 512,
  parameter int unsigned MAX_GAP = 255,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1),
  parameter int unsigned GAP_W   = $clog2(MAX_GAP + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [LEN_W-1:0]    pre_len_i,
  input  logic [LEN_W-1:0]    post_len_i,
  input  logic [GAP_W-1:0]    gap_len_i,
  input  logic                fire_i,
  input  logic [TS_W-1:0]     ts_i,
  output logic                sums_valid_o,
  output logic                evt_valid_o,
  output logic                evt_ok_o,
  output logic [SUM_W-1:0]    evt_pre_o,
  output logic [SUM_W-1:0]    evt_post_o,
  output logic [TS_W-1:0]     evt_ts_o,
  output logic                prev_valid_o,
  output logic                prev_ok_o,
  output logic [SUM_W-1:0]    prev_pre_o,
  output logic [SUM_W-1:0]    prev_post_o,
  output logic [TS_W-1:0]     prev_ts_o
);
  localparam int unsigned WIN_AW = $clog2(MAX_LEN);
  localparam int unsigned GAP_AW = $clog2(MAX_GAP + 1);
  localparam int unsigned TOT_W  = $clog2(2 * MAX_LEN + MAX_GAP + 1);

  logic [LEN_W-1:0]    pre_len_q, post_len_q;
  logic [GAP_W-1:0]    gap_len_q;
  logic                restart;
  logic [TOT_W-1:0]    tot_q, target;
  logic [SAMPLE_W-1:0] post_leave, gap_out, pre_leave;
  logic [SUM_W-1:0]    pre_sum, post_sum;
  psa_evt_t            cur, prev;

  assign restart = (pre_len_i != pre_len_q) || (post_len_i != post_len_q) ||
                   (gap_len_i != gap_len_q);
  assign target  = TOT_W'(pre_len_i) + TOT_W'(post_len_i) + TOT_W'(gap_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_len_q  <= '0;
      post_len_q <= '0;
      gap_len_q  <= '0;
      tot_q      <= '0;
    end else begin
      pre_len_q  <= pre_len_i;
      post_len_q <= post_len_i;
      gap_len_q  <= gap_len_i;
      if (restart)             tot_q <= '0;
      else if (tot_q < target) tot_q <= tot_q + 1'b1;
    end
  end

  assign sums_valid_o = (tot_q >= target) && !restart;

  // newest samples: post window, then gap, then pre window
  psa_delay #(.AW(WIN_AW), .LEN_W(LEN_W)) u_post_dly (
    .clk_i, .rst_ni, .restart_i(restart), .len_i(post_len_i),
    .din_i(sample_i), .dout_o(post_leave));

  psa_delay #(.AW(GAP_AW), .LEN_W(GAP_W)) u_gap_dly (
    .clk_i, .rst_ni, .restart_i(restart), .len_i(gap_len_i),
    .din_i(post_leave), .dout_o(gap_out));

  psa_delay #(.AW(WIN_AW), .LEN_W(LEN_W)) u_pre_dly (
    .clk_i, .rst_ni, .restart_i(restart), .len_i(pre_len_i),
    .din_i(gap_out), .dout_o(pre_leave));

  psa_accum #(.LEN_W(LEN_W)) u_post_acc (
    .clk_i, .rst_ni, .restart_i(restart), .len_i(post_len_i),
    .add_i(sample_i), .sub_i(post_leave), .sum_o(post_sum));

  psa_accum #(.LEN_W(LEN_W)) u_pre_acc (
    .clk_i, .rst_ni, .restart_i(restart), .len_i(pre_len_i),
    .add_i(gap_out), .sub_i(pre_leave), .sum_o(pre_sum));

  psa_event_latch u_latch (
    .clk_i, .rst_ni, .fire_i, .ok_i(sums_valid_o), .pre_i(pre_sum),
    .post_i(post_sum), .ts_i, .cur_o(cur), .cur_valid_o(evt_valid_o),
    .prev_o(prev), .prev_valid_o);

  assign evt_ok_o    = cur.ok;
  assign evt_pre_o   = cur.pre;
  assign evt_post_o  = cur.post;
  assign evt_ts_o    = cur.ts;
  assign prev_ok_o   = prev.ok;
  assign prev_pre_o  = prev.pre;
  assign prev_post_o = prev.post;
  assign prev_ts_o   = prev.ts;

  p_restart_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !sums_valid_o);
  p_valid_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sums_valid_o |=> sums_valid_o || restart);
endmodule

// File: tb/prepost_sum_unit_tb_top.sv
module prepost_sum_unit_tb_top;
  import psa_pkg::*;
  localparam int LEN_W = 10;
  localparam int GAP_W = 8;

  logic clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  logic                rst_ni;
  logic [SAMPLE_W-1:0] sample_i;
  logic [LEN_W-1:0]    pre_len_i, post_len_i;
  logic [GAP_W-1:0]    gap_len_i;
  logic                fire_i;
  logic [TS_W-1:0]     ts_i;
  logic                sums_valid_o, evt_valid_o, evt_ok_o, prev_valid_o, prev_ok_o;
  logic [SUM_W-1:0]    evt_pre_o, evt_post_o, prev_pre_o, prev_post_o;
  logic [TS_W-1:0]     evt_ts_o, prev_ts_o;

  prepost_sum_unit dut_i (
    .clk_i, .rst_ni, .sample_i, .pre_len_i, .post_len_i, .gap_len_i, .fire_i,
    .ts_i, .sums_valid_o, .evt_valid_o, .evt_ok_o, .evt_pre_o, .evt_post_o,
    .evt_ts_o, .prev_valid_o, .prev_ok_o, .prev_pre_o, .prev_post_o, .prev_ts_o);

  typedef struct {
    bit              ok;
    longint          pre;
    longint          post;
    logic [TS_W-1:0] ts;
  } exp_t;

  int errors = 0, checks = 0;
  int n = 0, m = -1;
  int lpre = 4, lpost = 3, lgap = 2;
  int a_pre = 4, a_post = 3, a_gap = 2;
  bit chg = 0, started = 0, done = 0, have_last = 0;
  string tag = "R1";
  logic [SAMPLE_W-1:0] hist [0:16383];
  exp_t q[$];
  exp_t last, mon_e;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint wsum(input int lo, input int hi);
    longint s = 0;
    for (int i = lo; i <= hi; i++) s += longint'(hist[i]);
    return s;
  endfunction

  task automatic set_lens(input int p, input int s, input int g, input string t);
    lpre = p; lpost = s; lgap = g; chg = 1; tag = t;
  endtask

  // driver: applies one cycle of stimulus and predicts the record of a fire
  task automatic drive(input logic [SAMPLE_W-1:0] s, input bit f);
    exp_t e;
    @(negedge clk_i);
    pre_len_i  = LEN_W'(lpre);
    post_len_i = LEN_W'(lpost);
    gap_len_i  = GAP_W'(lgap);
    a_pre = lpre; a_post = lpost; a_gap = lgap;
    if (chg) begin m = n; chg = 0; end
    sample_i = s;
    fire_i   = f;
    ts_i     = TS_W'(64'hAB0000 + 64'(n) * 7);
    hist[n]  = s;
    if (f) begin
      e.ok   = (n - m - 1) >= (a_pre + a_post + a_gap);
      e.post = e.ok ? wsum(n - a_post, n - 1) : 0;
      e.pre  = e.ok ? wsum(n - a_post - a_gap - a_pre, n - a_post - a_gap - 1) : 0;
      e.ts   = ts_i;
      q.push_back(e);
    end
    n++;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (started && !done) begin
        if (evt_valid_o) begin
          if (q.size() == 0) begin
            check("R6", "unexpected evt_valid_o", 1, 0);
          end else begin
            mon_e = q.pop_front();
            check("R8", "evt_ok_o", longint'(evt_ok_o), longint'(mon_e.ok));
            check("R5", "evt_ts_o", longint'(evt_ts_o), longint'(mon_e.ts));
            if (mon_e.ok) begin
              check({"R1/", tag}, "evt_post_o", longint'(evt_post_o), mon_e.post);
              check({"R2/", tag}, "evt_pre_o", longint'(evt_pre_o), mon_e.pre);
            end
            if (have_last) begin
              check("R7", "prev_valid_o", longint'(prev_valid_o), 1);
              check("R7", "prev_ts_o", longint'(prev_ts_o), longint'(last.ts));
              check("R7", "prev_ok_o", longint'(prev_ok_o), longint'(last.ok));
              if (last.ok) begin
                check("R7", "prev_post_o", longint'(prev_post_o), last.post);
                check("R7", "prev_pre_o", longint'(prev_pre_o), last.pre);
              end
            end else begin
              check("R7", "prev_valid_o before second fire", longint'(prev_valid_o), 0);
            end
            last = mon_e;
            have_last = 1;
          end
        end else begin
          if (q.size() != 0) begin
            void'(q.pop_front());
            check("R6", "missing evt_valid_o", 0, 1);
          end
          if (have_last) begin
            check("R10", "evt_ts_o held", longint'(evt_ts_o), longint'(last.ts));
            if (last.ok) check("R10", "evt_post_o held", longint'(evt_post_o), last.post);
          end
        end
        check("R8", "sums_valid_o", longint'(sums_valid_o),
              longint'((n - m - 1) >= (a_pre + a_post + a_gap)));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_ni     = 1'b0;
    sample_i   = '0;
    fire_i     = 1'b0;
    ts_i       = '0;
    pre_len_i  = LEN_W'(lpre);
    post_len_i = LEN_W'(lpost);
    gap_len_i  = GAP_W'(lgap);
    repeat (3) @(negedge clk_i);
    check("R9", "sums_valid_o in reset", longint'(sums_valid_o), 0);
    check("R9", "evt_valid_o in reset", longint'(evt_valid_o), 0);
    check("R9", "prev_valid_o in reset", longint'(prev_valid_o), 0);
    check("R9", "evt_pre_o in reset", longint'(evt_pre_o), 0);
    check("R9", "evt_post_o in reset", longint'(evt_post_o), 0);
    check("R9", "evt_ts_o in reset", longint'(evt_ts_o), 0);
    rst_ni  = 1'b1;
    m       = -1;
    started = 1;

    // R1 R2 R8: short windows, early fire before the windows are full
    for (int i = 0; i < 12; i++) drive(SAMPLE_W'($urandom_range(0, 16383)), i == 5);
    // R6: back-to-back fires
    for (int i = 0; i < 20; i++)
      drive(SAMPLE_W'($urandom_range(0, 16383)), (i >= 3 && i <= 5) || i == 12);

    // R4: zero gap, one-sample windows, fire in the restart cycle
    set_lens(1, 1, 0, "R4");
    drive(SAMPLE_W'($urandom_range(0, 16383)), 1'b1);
    for (int i = 0; i < 6; i++) drive(SAMPLE_W'($urandom_range(0, 16383)), i >= 1);

    // R3: longest windows and gap, full-scale samples
    set_lens(512, 512, 255, "R3");
    for (int i = 0; i < 1300; i++)
      drive(SAMPLE_W'(16383), i == 1279 || i == 1280 || i == 1295 || i == 1296);

    // R2: ramp with maximum gap and uneven windows
    set_lens(9, 6, 255, "R2");
    for (int i = 0; i < 300; i++)
      drive(SAMPLE_W'(i * 37 + 5), i == 280 || i == 281 || i == 290);

    for (int i = 0; i < 3; i++) drive('0, 1'b0);
    @(negedge clk_i);
    done = 1;
    finish_run();
  end
endmodule